// File: doc/BRIEF.md
# Ready/Valid Queue Ordering Monitor

This block is a synthesizable observer that sits next to a ready/valid queue carrying byte-wide data. It watches the handshakes on both sides of the queue along with the occupancy the queue reports. It raises sticky error flags when the queue loses, repeats or reorders data, when its reported fill level is wrong, or when the surrounding stimulus starves the handshakes. The monitor never drives the queue; it only samples the queue's pins.

The monitor does not keep a full shadow copy of the queue. It counts accepted and delivered transfers in two saturating counters. It follows one transfer position, chosen by a static `watchIndex` input, and captures the byte accepted at that position and the byte delivered at that position. After both sides have moved past that position, the two bytes must match. The occupancy checks come from the difference between the two counters and from a separate up/down fill tracker. A counter stops at its all-ones value; from then on, positions are no longer tracked exactly.

Top module: `rv_order_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `errFlags` and `errAny` read zero. No check runs in a cycle in which `rst` is sampled high.
- R2: A fill tracker starts at 0. It goes up by one when only the input side fires, goes down by one when only the output side fires, and holds otherwise. If it differs from `fifoCount` in a checked cycle, bit 0 of `errFlags` is set at that clock edge.
- R3: Once the accepted-transfer count and the delivered-transfer count both exceed `watchIndex`, bit 5 is set if the byte captured at that input position differs from the byte captured at that output position.
- R4: If the delivered-transfer count is ever greater than the accepted-transfer count, bit 3 is set.
- R5: While neither transfer counter is at all-ones, bit 4 is set when the fill tracker differs from accepted minus delivered. Once either counter is at all-ones, bit 4 is set only when the fill tracker is below that difference.
- R6: While the accepted count is below `watchIndex`, the input capture register must be zero, or bit 1 is set. While the delivered count is below `watchIndex`, the output capture register must be zero, or bit 2 is set. Both capture registers reset to zero.
- R7: Two 3-bit histories record `inValid` and `outReady` and reset to all ones. If the histories show no cycle among the last three in which both were high, bit 6 is set one edge later. After three such cycles following reset, the flag is still clear, and it is set after the fourth.
- R8: `watchIndex` equal to all ones is illegal, and bit 7 is set in any checked cycle in which it has that value.
- R9: Every flag bit, once set, stays set until reset, and `errAny` is the OR of all eight bits.
- R10: Correct, in-order traffic with a matching `fifoCount` and fair handshakes sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Queue input side: valid |
| inReady | input | 1 | Queue input side: ready |
| inData | input | DATA_W | Queue input side: data |
| outValid | input | 1 | Queue output side: valid |
| outReady | input | 1 | Queue output side: ready |
| outData | input | DATA_W | Queue output side: data |
| fifoCount | input | OCC_W | Occupancy reported by the queue |
| watchIndex | input | CNT_W | Transfer position to follow; held constant |
| errFlags | output | 8 | Sticky error bits, in the bit order given in R2 to R8 |
| errAny | output | 1 | OR of all error bits |

## Verification
A fill tracker or transfer counter that is off by one appears on the pins as bit 0 or bit 4 one edge after the cycle in which it goes wrong. A capture register loaded at the wrong position shows up as bit 1, or as bit 5 once both counters pass the watched index. A fairness history that shifts too early or too late moves the bit-6 edge by one cycle, so the bench samples the cycle before and the cycle after that boundary. A flag that loses its value or never clears shows up in the sticky and reset checks.

// File: rtl/rvm_pkg.sv
package rvm_pkg;
  localparam int NUM_ERR   = 8;
  localparam int ERR_COUNT = 0;
  localparam int ERR_CAPIN = 1;
  localparam int ERR_CAPOUT = 2;
  localparam int ERR_ORDER = 3;
  localparam int ERR_DIFF  = 4;
  localparam int ERR_DATA  = 5;
  localparam int ERR_FAIR  = 6;
  localparam int ERR_INDEX = 7;

  // strobes from control to the capture datapath
  typedef struct packed {
    logic capIn;     // load input capture register
    logic capOut;    // load output capture register
    logic inBelow;   // accepted count below watched index
    logic outBelow;  // delivered count below watched index
    logic bothPast;  // both counts beyond watched index
  } strobe_t;
endpackage

// File: rtl/rvm_ctrl.sv
module rvm_ctrl
  import rvm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int OCC_W  = 8,
  parameter int HIST_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inReady,
  input  logic             outValid,
  input  logic             outReady,
  input  logic [OCC_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] watchIndex,
  output strobe_t          strobes,
  output logic             countErr,
  output logic             orderErr,
  output logic             diffErr,
  output logic             fairErr,
  output logic             indexErr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  inCnt, outCnt;
  logic [OCC_W-1:0]  expOcc;
  logic [HIST_W-1:0] inHist, outHist;
  logic              inFire, outFire;
  logic              saturated;
  logic [CNT_W-1:0]  cntDiff, occWide;

  assign inFire  = inValid && inReady;
  assign outFire = outValid && outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      inCnt   <= '0;
      outCnt  <= '0;
      expOcc  <= '0;
      inHist  <= '1;
      outHist <= '1;
    end else begin
      if (inFire && inCnt != CNT_MAX) inCnt <= inCnt + 1'b1;
      if (outFire && outCnt != CNT_MAX) outCnt <= outCnt + 1'b1;
      case ({inFire, outFire})
        2'b10:   expOcc <= expOcc + 1'b1;
        2'b01:   expOcc <= expOcc - 1'b1;
        default: expOcc <= expOcc;
      endcase
      inHist  <= {inHist[HIST_W-2:0], inValid};
      outHist <= {outHist[HIST_W-2:0], outReady};
    end
  end

  always_comb begin
    strobes.capIn    = inFire && (inCnt == watchIndex);
    strobes.capOut   = outFire && (outCnt == watchIndex);
    strobes.inBelow  = inCnt < watchIndex;
    strobes.outBelow = outCnt < watchIndex;
    strobes.bothPast = (inCnt > watchIndex) && (outCnt > watchIndex);
  end

  assign saturated = (inCnt == CNT_MAX) || (outCnt == CNT_MAX);
  assign cntDiff   = inCnt - outCnt;
  assign occWide   = CNT_W'(expOcc);

  assign countErr = expOcc != fifoCount;
  assign orderErr = outCnt > inCnt;
  assign diffErr  = saturated ? (occWide < cntDiff) : (occWide != cntDiff);
  assign fairErr  = (inHist & outHist) == '0;
  assign indexErr = watchIndex == CNT_MAX;
endmodule

// File: rtl/rvm_data.sv
module rvm_data
  import rvm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] outData,
  input  strobe_t           strobes,
  output logic              capInErr,
  output logic              capOutErr,
  output logic              dataErr
);
  logic [DATA_W-1:0] capInReg, capOutReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      capInReg  <= '0;
      capOutReg <= '0;
    end else begin
      if (strobes.capIn)  capInReg  <= inData;
      if (strobes.capOut) capOutReg <= outData;
    end
  end

  assign capInErr  = strobes.inBelow && (capInReg != '0);
  assign capOutErr = strobes.outBelow && (capOutReg != '0);
  assign dataErr   = strobes.bothPast && (capInReg != capOutReg);
endmodule

// File: rtl/rvm_flags.sv
module rvm_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] viol,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flags[i] <= 1'b0;
      else if (viol[i]) flags[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/rv_order_monitor.sv
module rv_order_monitor
  import rvm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32,
  parameter int OCC_W  = 8,
  parameter int HIST_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               inReady,
  input  logic [DATA_W-1:0]  inData,
  input  logic               outValid,
  input  logic               outReady,
  input  logic [DATA_W-1:0]  outData,
  input  logic [OCC_W-1:0]   fifoCount,
  input  logic [CNT_W-1:0]   watchIndex,
  output logic [NUM_ERR-1:0] errFlags,
  output logic               errAny
);
  strobe_t            strobes;
  logic [NUM_ERR-1:0] viol;

  rvm_ctrl #(.CNT_W(CNT_W), .OCC_W(OCC_W), .HIST_W(HIST_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady),
    .fifoCount(fifoCount), .watchIndex(watchIndex),
    .strobes(strobes),
    .countErr(viol[ERR_COUNT]), .orderErr(viol[ERR_ORDER]),
    .diffErr(viol[ERR_DIFF]), .fairErr(viol[ERR_FAIR]),
    .indexErr(viol[ERR_INDEX])
  );

  rvm_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst),
    .inData(inData), .outData(outData),
    .strobes(strobes),
    .capInErr(viol[ERR_CAPIN]), .capOutErr(viol[ERR_CAPOUT]),
    .dataErr(viol[ERR_DATA])
  );

  rvm_flags #(.N(NUM_ERR)) u_flags (
    .clk(clk), .rst(rst), .viol(viol), .flags(errFlags)
  );

  assign errAny = |errFlags;
endmodule

// File: rtl/rv_order_monitor_chk.sv
module rv_order_monitor_chk
  import rvm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int OCC_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic               outReady,
  input logic [OCC_W-1:0]   fifoCount,
  input logic [CNT_W-1:0]   watchIndex,
  input logic [NUM_ERR-1:0] errFlags
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> errFlags == '0);

  // R9
  sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R8
  bad_index_chk: assert property (@(posedge clk) disable iff (rst)
    (watchIndex == '1) |=> errFlags[ERR_INDEX]);

  // R2
  first_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && fifoCount != '0) |=> errFlags[ERR_COUNT]);

  // R7
  starve_chk: assert property (@(posedge clk) disable iff (rst)
    (!(inValid && outReady) && !$past(inValid && outReady)
     && !$past(inValid && outReady, 2) && !$past(rst) && !$past(rst, 2))
    |-> ##2 errFlags[ERR_FAIR]);
endmodule

bind rv_order_monitor rv_order_monitor_chk #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
  .fifoCount(fifoCount), .watchIndex(watchIndex), .errFlags(errFlags)
);

// File: tb/tb_rv_order_monitor.sv
module tb_rv_order_monitor;
  localparam logic [7:0] F_COUNT = 8'h01, F_CAPIN = 8'h02, F_ORDER = 8'h08,
                         F_DIFF = 8'h10, F_DATA = 8'h20, F_FAIR = 8'h40, F_INDEX = 8'h80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0, inReady = 1'b0, outValid = 1'b0, outReady = 1'b0;
  logic [7:0]  inData = '0, outData = '0, fifoCount = '0;
  logic [31:0] watchIndex = 32'd2;
  logic [7:0]  errFlags;
  logic        errAny;
  int          nRun = 0, nFail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rv_order_monitor dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .fifoCount(fifoCount), .watchIndex(watchIndex),
    .errFlags(errFlags), .errAny(errAny)
  );

  typedef struct packed {
    logic iv; logic ir; logic [7:0] id;
    logic ov; logic orr; logic [7:0] od;
    logic [7:0] cnt; logic [7:0] expF;
  } vec_t;

  // in-order traffic, watched index 2, fill level presented before each cycle
  localparam vec_t TABLE [6] = '{
    '{1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 8'h00, 8'd0, 8'h00},
    '{1'b1, 1'b1, 8'h22, 1'b1, 1'b1, 8'h11, 8'd1, 8'h00},
    '{1'b1, 1'b1, 8'h33, 1'b1, 1'b1, 8'h22, 8'd1, 8'h00},
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h33, 8'd1, 8'h00},
    '{1'b1, 1'b1, 8'h44, 1'b0, 1'b1, 8'h00, 8'd0, 8'h00},
    '{1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h44, 8'd1, 8'h00}
  };

  task automatic check(input logic [7:0] expF, input string req);
    nRun++;
    if (errFlags !== expF || errAny !== (expF != 8'h00)) begin
      nFail++;
      $display("FAIL %s: flags=%h any=%b expected flags=%h any=%b",
               req, errFlags, errAny, expF, expF != 8'h00);
    end
  endtask

  task automatic cycle(input logic iv, input logic ir, input logic [7:0] id,
                       input logic ov, input logic orr, input logic [7:0] od,
                       input logic [7:0] cnt);
    inValid = iv; inReady = ir; inData = id;
    outValid = ov; outReady = orr; outData = od; fifoCount = cnt;
    @(posedge clk); #1;
  endtask

  // fair idle: no transfer, but valid and ready both high
  task automatic idle(input logic [7:0] cnt);
    cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, cnt);
  endtask

  task automatic doReset(input logic [31:0] idx);
    rst = 1'b1; watchIndex = idx;
    inValid = 1'b0; inReady = 1'b0; outValid = 1'b0; outReady = 1'b0; fifoCount = 8'd3;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a wrong fill level present during reset
    doReset(32'd2);
    check(8'h00, "R1 reset");

    // R10: table walk of correct traffic
    foreach (TABLE[i]) begin
      cycle(TABLE[i].iv, TABLE[i].ir, TABLE[i].id, TABLE[i].ov, TABLE[i].orr,
            TABLE[i].od, TABLE[i].cnt);
      check(TABLE[i].expF, "R10 clean traffic");
    end
    idle(8'd0);
    check(8'h00, "R10 clean traffic, both past index");

    // R2 and R9: wrong fill level, then sticky
    doReset(32'd5);
    idle(8'd3);
    check(F_COUNT, "R2 fill mismatch");
    idle(8'd0);
    idle(8'd0);
    check(F_COUNT, "R9 flag stays set");

    // R3: reordered data at watched index 0
    doReset(32'd0);
    cycle(1'b1, 1'b1, 8'h5A, 1'b0, 1'b1, 8'h00, 8'd0);
    cycle(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'hA5, 8'd1);
    check(8'h00, "R3 not yet past on output side");
    idle(8'd0);
    check(F_DATA, "R3 data mismatch");

    // R4 and R5: delivery with nothing accepted
    doReset(32'd5);
    cycle(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'd0);
    check(8'h00, "R4 before check edge");
    idle(8'd0);
    check(F_COUNT | F_ORDER | F_DIFF, "R4 R5 output ahead of input");

    // R6: capture nonzero while below index
    doReset(32'd0);
    cycle(1'b1, 1'b1, 8'h77, 1'b0, 1'b1, 8'h00, 8'd0);
    watchIndex = 32'd5;
    idle(8'd1);
    check(F_CAPIN, "R6 capture below index");

    // R7: starvation boundary
    doReset(32'd5);
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'd0);
    check(8'h00, "R7 three starved cycles");
    cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'd0);
    check(F_FAIR, "R7 fourth edge");

    // R8: illegal watched index
    doReset(32'hFFFF_FFFF);
    idle(8'd0);
    check(F_INDEX, "R8 all-ones index");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule